// File: doc/BRIEF.md
# Microcoded Memory Timing Sequencer

This block drives the control pins of an external memory from a small writable table of microcode words instead of a hard-wired state machine. Each word covers one bus clock of an access. It sets the address-multiplexer select, requests a column-address step, gives the transfer-acknowledge level for that clock, and holds a 4-bit waveform for each control strobe. The four bits of a strobe are its levels in the four quarters of the bus clock. A word also carries an end-of-pattern flag.

The block runs on a clock four times faster than the bus clock. A free-running two-bit quarter counter marks the bus-clock phases and is brought out so that surrounding logic can align to it. Software loads the table through a plain address/data write port while the sequencer is idle. The memory controller then raises a request with one of four access types: single read, single write, burst read or burst write. Each type starts its pattern at its own fixed slot of eight words. During bursts the sequencer also keeps the low column address that feeds the memory.

Top module: `mem_timing_seq`

## Requirements
- R1: After reset the sequencer is idle: `seqBusy`=0, every `strobeOut` bit is 1 (negated), `xferAck`=0, `addrMuxSel`=0 and `quarterPhase`=0.
- R2: An idle sequencer samples `reqValid` only on the clock edge that ends quarter 3. The first word's quarter 0 appears right after that edge. Word index = `reqType`×8, where `reqType` is 00 single read, 01 single write, 10 burst read and 11 burst write.
- R3: While busy, `strobeOut[i]` in quarter q equals bit 4·i+q of the current word, for i = 0..6.
- R4: While busy, `xferAck` equals word bit 30 and `addrMuxSel` equals word bit 28, each held for all four quarters of that word.
- R5: A word with bit 31 set is the last one. After its quarter 3 the sequencer is idle and all strobes return to 1.
- R6: If no word of a slot has bit 31 set, the pattern ends after the eighth word of the slot.
- R7: `colAddr` loads `reqCol` when a request is accepted. For burst types (`reqType` bit 1 = 1) it steps by one after every word whose bit 29 is set, wrapping modulo 2^COL_W, and it holds after the access.
- R8: For single types, word bit 29 leaves `colAddr` unchanged.
- R9: A table write is stored at `tblWrAddr` when the sequencer is idle. A write presented while busy is discarded.
- R10: `quarterPhase` counts 0,1,2,3,0… on every clock edge after reset, whether busy or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock (4× bus clock) |
| rst | input | 1 | Synchronous reset, active high |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | 6 | Table word index |
| tblWrData | input | 32 | Microcode word to store |
| reqValid | input | 1 | Access request |
| reqType | input | 2 | Access type selecting the pattern slot |
| reqCol | input | 4 | Starting low column address |
| strobeOut | output | 7 | Control strobe levels, 1 = negated |
| addrMuxSel | output | 1 | Row/column address multiplexer select |
| xferAck | output | 1 | Transfer acknowledge for the current bus clock |
| colAddr | output | 4 | Low column address, stepped in bursts |
| seqBusy | output | 1 | Pattern in progress |
| quarterPhase | output | 2 | Current quarter of the bus clock |

## Verification
If the program counter is wrong, the wrong word's waveform reaches the strobes in the very next quarter. A per-quarter comparison against the loaded pattern catches it within one bus clock. A stale phase count or a missed end flag shows up as `seqBusy` and the strobes staying active one quarter past the expected end, or as a start at a quarter other than 0. A broken column counter shows at the first burst beat after the faulty step, and at the wrap from the top value to zero.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int WORD_W   = 32;
  localparam int QUARTERS = 4;
  localparam int MUX_BIT  = 28;
  localparam int INCR_BIT = 29;
  localparam int ACK_BIT  = 30;
  localparam int LAST_BIT = 31;

  typedef struct packed {
    logic       running;
    logic [1:0] phase;
    logic       loadWord;
    logic       startAcc;
    logic       beatEnd;
    logic       burst;
  } ctlStrobes_t;
endpackage

// File: rtl/mseq_table.sv
module mseq_table #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busy,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [mseq_pkg::WORD_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [mseq_pkg::WORD_W-1:0]  rdData
);
  logic [mseq_pkg::WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wrEn && !busy) begin
      mem[wrAddr] <= wrData;
    end
  end

  assign rdData = mem[rdAddr];

  // R9: writes while the pattern runs leave the table untouched
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wrEn && busy) |=> mem[$past(wrAddr)] == $past(mem[wrAddr]));
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SLOT_WORDS = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(SLOT_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic              lastBit,
  output logic [ADDR_W-1:0] wordIdx,
  output ctlStrobes_t       ctl
);
  logic              running;
  logic [1:0]        qPhase;
  logic [ADDR_W-1:0] pc;
  logic [1:0]        accType;
  logic              accept, isBeatEnd, slotEnd, endNow, loadWord;
  logic [ADDR_W-1:0] baseIdx;

  always_comb begin
    isBeatEnd = running && (qPhase == 2'd3);
    accept    = !running && reqValid && (qPhase == 2'd3);
    slotEnd   = &pc[SLOT_W-1:0];
    endNow    = isBeatEnd && (lastBit || slotEnd);
    baseIdx   = ADDR_W'(reqType) << SLOT_W;
    wordIdx   = accept ? baseIdx : pc + ADDR_W'(1);
    loadWord  = accept || (isBeatEnd && !endNow);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      qPhase  <= 2'd0;
      pc      <= '0;
      accType <= 2'd0;
    end else begin
      qPhase <= qPhase + 2'd1;
      if (accept) begin
        running <= 1'b1;
        accType <= reqType;
      end else if (endNow) begin
        running <= 1'b0;
      end
      if (loadWord) pc <= wordIdx;
    end
  end

  assign ctl = '{running:  running,
                 phase:    qPhase,
                 loadWord: loadWord,
                 startAcc: accept,
                 beatEnd:  isBeatEnd,
                 burst:    accType[1]};

  // R10: quarter counter advances by one each edge
  assert_phase_step_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> qPhase == $past(qPhase) + 2'd1);

  // R2: an access only begins after quarter 3
  assert_start_after_q3_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(qPhase) == 2'd3);

  // R6: the program counter never leaves the slot of its access type
  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (rst)
    running |-> (pc >> SLOT_W) == ADDR_W'(accType));
endmodule

// File: rtl/mseq_datapath.sv
module mseq_datapath
  import mseq_pkg::*;
#(
  parameter int NUM_STROBES = 7,
  parameter int COL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctlStrobes_t            ctl,
  input  logic [WORD_W-1:0]      rdData,
  input  logic [COL_W-1:0]       reqCol,
  output logic                   lastBit,
  output logic [NUM_STROBES-1:0] strobeOut,
  output logic                   addrMuxSel,
  output logic                   xferAck,
  output logic [COL_W-1:0]       colAddr
);
  logic [WORD_W-1:0] curWord;
  logic              colStep;

  always_ff @(posedge clk) begin
    if (rst) curWord <= '0;
    else if (ctl.loadWord) curWord <= rdData;
  end

  assign colStep = ctl.beatEnd && ctl.burst && curWord[INCR_BIT];

  always_ff @(posedge clk) begin
    if (rst) colAddr <= '0;
    else if (ctl.startAcc) colAddr <= reqCol;
    else if (colStep) colAddr <= colAddr + COL_W'(1);
  end

  generate
    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
      logic [QUARTERS-1:0] wave;
      assign wave = curWord[i*QUARTERS +: QUARTERS];
      assign strobeOut[i] = ctl.running ? wave[ctl.phase] : 1'b1;
    end
  endgenerate

  assign lastBit    = curWord[LAST_BIT];
  assign addrMuxSel = ctl.running && curWord[MUX_BIT];
  assign xferAck    = ctl.running && curWord[ACK_BIT];

  // R3: the word stays put until the end of its bus clock
  assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.running && ctl.phase != 2'd3) |=> $stable(curWord));

  // R7: the column address only moves at a beat boundary
  assert_col_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.running && ctl.phase != 2'd3) |=> $stable(colAddr));

  // R8: single accesses never move the column address
  assert_single_col_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.running && !ctl.burst) |=> $stable(colAddr));
endmodule

// File: rtl/mem_timing_seq.sv
module mem_timing_seq
  import mseq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SLOT_WORDS = 8,
  parameter int NUM_STROBES = 7,
  parameter int COL_W = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tblWrEn,
  input  logic [ADDR_W-1:0]      tblWrAddr,
  input  logic [WORD_W-1:0]      tblWrData,
  input  logic                   reqValid,
  input  logic [1:0]             reqType,
  input  logic [COL_W-1:0]       reqCol,
  output logic [NUM_STROBES-1:0] strobeOut,
  output logic                   addrMuxSel,
  output logic                   xferAck,
  output logic [COL_W-1:0]       colAddr,
  output logic                   seqBusy,
  output logic [1:0]             quarterPhase
);
  ctlStrobes_t       ctl;
  logic [ADDR_W-1:0] wordIdx;
  logic [WORD_W-1:0] rdData;
  logic              lastBit;

  mseq_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .rst(rst), .busy(ctl.running),
    .wrEn(tblWrEn), .wrAddr(tblWrAddr), .wrData(tblWrData),
    .rdAddr(wordIdx), .rdData(rdData));

  mseq_ctrl #(.DEPTH(DEPTH), .SLOT_WORDS(SLOT_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqType(reqType),
    .lastBit(lastBit), .wordIdx(wordIdx), .ctl(ctl));

  mseq_datapath #(.NUM_STROBES(NUM_STROBES), .COL_W(COL_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rdData(rdData), .reqCol(reqCol),
    .lastBit(lastBit), .strobeOut(strobeOut), .addrMuxSel(addrMuxSel),
    .xferAck(xferAck), .colAddr(colAddr));

  assign seqBusy      = ctl.running;
  assign quarterPhase = ctl.phase;
endmodule

// File: tb/sim_mem_timing_seq.sv
module sim_mem_timing_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        tblWrEn;
  logic [5:0]  tblWrAddr;
  logic [31:0] tblWrData;
  logic        reqValid;
  logic [1:0]  reqType;
  logic [3:0]  reqCol;
  logic [6:0]  strobeOut;
  logic        addrMuxSel, xferAck, seqBusy;
  logic [3:0]  colAddr;
  logic [1:0]  quarterPhase;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] pat [8];

  always #5 clk = ~clk;

  mem_timing_seq u0 (
    .clk(clk), .rst(rst), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData), .reqValid(reqValid), .reqType(reqType),
    .reqCol(reqCol), .strobeOut(strobeOut), .addrMuxSel(addrMuxSel),
    .xferAck(xferAck), .colAddr(colAddr), .seqBusy(seqBusy),
    .quarterPhase(quarterPhase));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic loadSlot(input logic [1:0] typ);
    // R9: idle writes land at the given index
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tblWrEn = 1'b1;
      tblWrAddr = {typ, 3'b000} + 6'(i);
      tblWrData = pat[i];
    end
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // Caller stands at a negedge; request is raised there.
  task automatic runAccess(input logic [1:0] typ, input logic [3:0] col,
                           input bit busyWrite, input string endTag);
    int nw = 8;
    int waits = 0;
    int p0;
    logic [3:0] ce = col;
    logic [6:0] es;
    for (int i = 7; i >= 0; i--) if (pat[i][31]) nw = i + 1;
    p0 = int'(quarterPhase);
    reqValid = 1'b1; reqType = typ; reqCol = col;
    while (!seqBusy && waits < 10) begin
      @(negedge clk);
      waits++;
    end
    reqValid = 1'b0;
    chk("R2 wait quarters", 64'(waits), 64'(4 - p0));
    chk("R2 start quarter", 64'(quarterPhase), 64'd0);
    for (int w = 0; w < nw; w++) begin
      for (int q = 0; q < 4; q++) begin
        if (!(w == 0 && q == 0)) @(negedge clk);
        if (busyWrite && w == 0 && q == 0) begin
          tblWrEn = 1'b1; tblWrAddr = {typ, 3'b001}; tblWrData = ~pat[1];
        end
        if (busyWrite && w == 0 && q == 1) tblWrEn = 1'b0;
        for (int i = 0; i < 7; i++) es[i] = pat[w][i*4+q];
        chk("R3 strobes", 64'(strobeOut), 64'(es));
        chk("R4 ack/mux", 64'({xferAck, addrMuxSel}), 64'({pat[w][30], pat[w][28]}));
        chk(typ[1] ? "R7 column" : "R8 column", 64'(colAddr), 64'(ce));
        chk("R9 busy during access", 64'(seqBusy), 64'd1);
      end
      if (typ[1] && pat[w][29]) ce = ce + 4'd1;
    end
    @(negedge clk);
    chk({endTag, " idle after pattern"}, 64'({seqBusy, strobeOut, xferAck}), 64'({1'b0, 7'h7F, 1'b0}));
    chk(typ[1] ? "R7 column held" : "R8 column held", 64'(colAddr), 64'(ce));
  endtask

  task automatic testReset();
    chk("R1 idle outputs", 64'({seqBusy, strobeOut, xferAck, addrMuxSel}),
        64'({1'b0, 7'h7F, 1'b0, 1'b0}));
    chk("R1 phase", 64'(quarterPhase), 64'd0);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R10 phase count", 64'(quarterPhase), 64'(k % 4));
    end
  endtask

  task automatic testRead();
    pat[0] = 32'h0AB0_0F3E; pat[1] = 32'h1F00_0F00; pat[2] = 32'hC0C3_0F37;
    for (int i = 3; i < 8; i++) pat[i] = 32'h0;
    loadSlot(2'b00);
    while (quarterPhase != 2'd0) @(negedge clk);
    runAccess(2'b00, 4'd3, 1'b0, "R5");
  endtask

  task automatic testWrite();
    pat[0] = 32'h2123_F7C1; pat[1] = 32'hE7F0_F0C3;
    for (int i = 2; i < 8; i++) pat[i] = 32'h0;
    loadSlot(2'b01);
    while (quarterPhase != 2'd3) @(negedge clk);
    runAccess(2'b01, 4'd9, 1'b0, "R5");  // R8: incr bits ignored
  endtask

  task automatic testBurstRead();
    pat[0] = 32'h3550_FF0E; pat[1] = 32'h60AA_FF0A; pat[2] = 32'h6012_FF0A;
    pat[3] = 32'hE0FF_FF0F;
    for (int i = 4; i < 8; i++) pat[i] = 32'h0;
    loadSlot(2'b10);
    while (quarterPhase != 2'd1) @(negedge clk);
    runAccess(2'b10, 4'd14, 1'b0, "R5");  // R7: 14,15,0,1 then 2
  endtask

  task automatic testBurstWriteBusyWrite();
    pat[0] = 32'h2F00_0A5F; pat[1] = 32'h6005_05AF; pat[2] = 32'hE0A0_0FFF;
    for (int i = 3; i < 8; i++) pat[i] = 32'h0;
    loadSlot(2'b11);
    @(negedge clk);
    runAccess(2'b11, 4'd0, 1'b1, "R9");
    @(negedge clk);
    runAccess(2'b11, 4'd7, 1'b0, "R9");
  endtask

  task automatic testNoLast();
    for (int i = 0; i < 8; i++) pat[i] = 32'h0ABC_DE00 | 32'(i * 17);
    loadSlot(2'b00);
    @(negedge clk);
    runAccess(2'b00, 4'd5, 1'b0, "R6");
  endtask

  initial begin
    rst = 1'b1; tblWrEn = 1'b0; tblWrAddr = '0; tblWrData = '0;
    reqValid = 1'b0; reqType = '0; reqCol = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testRead();
    testWrite();
    testBurstRead();
    testBurstWriteBusyWrite();
    testNoLast();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule